// File: doc/BRIEF.md
# Sobel Edge Accelerator

This block is a fixed-function loop engine for edge detection. After a start pulse it walks an output grid of `rows` by `cols` positions in raster order: row index outer, column index inner. For each position (i, j) it fetches the 3x3 window of 8-bit pixels whose top-left corner is at row i, column j. The source image therefore has to hold `rows + 2` rows and `cols + 2` columns. From the window it forms a horizontal gradient and a vertical gradient. It squares both, adds the squares, and writes a one-bit edge flag that says whether the sum is strictly above a threshold. Both dimensions must be at least 1.

The engine starts a new pixel every four cycles. Three read ports, one per window row, each fetch three pixels in the first three cycles of the interval and stay idle in the fourth. A single multiplier squares the horizontal gradient in one cycle and the vertical gradient in the next. Every read port has a fixed one-cycle latency. The dimensions and the threshold are captured at start, and a one-cycle done pulse follows the last flag write.

Top module: `sobelEdgeAccel`

## Requirements
- R1: While reset is held and after it is released, `rdEn`, `wrEn` and `done` are low.
- R2: Read addresses use this layout, with AW = DIM_W+1: the window row sits in bits [2*AW-1:AW] and the window column in bits [AW-1:0]. For pixel (i,j), port k (k = 0, 1, 2) reads row i+k at columns j, j+1 and j+2 in three consecutive cycles with `rdEn` high. `rdEn` is then low for one cycle. Read data is consumed on the cycle after its address.
- R3: Label the window pixels tRC (row offset R, column offset C). Define e1 = (t00+2*t01+t02) - (t20+2*t21+t22) and e2 = (t00+2*t10+t20) - (t02+2*t12+t22). The flag written for the pixel is 1 exactly when e1*e1 + e2*e2 is greater than the threshold. The centre pixel does not influence the flag.
- R4: Exactly one flag is written per output position, in raster order. `wrAddr` carries i in bits [2*AW-1:AW] and j in bits [AW-1:0].
- R5: `wrEn` is high for single cycles, and consecutive writes within a run are exactly 4 cycles apart.
- R6: The first read is issued in the cycle after start is sampled, and the first write appears 7 cycles after that first read.
- R7: `done` is high for exactly one cycle, the cycle after the final write. A start is accepted again from that cycle onward.
- R8: A start pulse during a run is ignored. Changes to `rows`, `cols` or `threshold` during a run have no effect on that run.
- R9: The comparison is strict. A sum equal to the threshold gives 0. A threshold of 0 flags every window with a nonzero gradient, and the maximal threshold flags none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, sampled while idle |
| rows | input | DIM_W | Output rows (>= 1) |
| cols | input | DIM_W | Output columns (>= 1) |
| threshold | input | 2*(PIX_W+3) | Edge threshold, unsigned |
| rdEn | output | 1 | Read strobe shared by the three ports |
| rdAddr | output | 3 x 2*(DIM_W+1) | Per-port read address {row, column} |
| rdData | input | 3 x PIX_W | Per-port read data, one cycle after the address |
| wrEn | output | 1 | Edge flag write strobe |
| wrAddr | output | 2*(DIM_W+1) | Edge flag address {i, j} |
| wrFlag | output | 1 | Edge flag value |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
On every cycle the assertions check the timing skeleton. That means the reset quietness, the shape of each three-cycle read burst with its column stepping and row offsets, the single-cycle write strobe, the fixed 4-cycle write spacing, and the placement and width of the done pulse. The arithmetic only shows up in the bench's scenarios, which compare every flag against gradients computed in the bench on random, uniform, binary and ramp images. Those scenarios also cover raster ordering of write addresses, the first-read and first-write latency, strictness at a threshold equal to the sum, and immunity to a start and to new configuration values arriving mid-run.

// File: rtl/sobelPkg.sv
package sobelPkg;
  // Per-cycle commands from the sequencer to the arithmetic
  typedef struct packed {
    logic       cfgLoad;    // capture threshold for a new run
    logic       capEn;      // store returning read data into the window
    logic [1:0] capIdx;     // window column being filled
    logic       gradLoad;   // register both gradients
    logic       sqLoad;     // register first square
    logic       mulSecond;  // multiplier takes the second gradient
    logic       outLoad;    // produce the edge flag write
  } sobelStrobes_t;
endpackage

// File: rtl/sobelCtrl.sv
module sobelCtrl
  import sobelPkg::*;
#(
  parameter int DIM_W = 4,
  localparam int AW = DIM_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIM_W-1:0] rows,
  input  logic [DIM_W-1:0] cols,
  output sobelStrobes_t    strobes,
  output logic             rdEn,
  output logic [AW-1:0]    rdRowBase,
  output logic [AW-1:0]    rdCol,
  output logic [DIM_W-1:0] outRow,
  output logic [DIM_W-1:0] outCol,
  output logic             done
);
  logic             busy;
  logic [1:0]       phase;
  logic [DIM_W-1:0] rowsQ, colsQ;
  // slot A: pixel being fetched, slot B: pixel being computed
  logic             aValid, bValid, bLast;
  logic [DIM_W-1:0] aI, aJ, bI, bJ;
  logic             aLast, aRowEnd;

  assign aRowEnd = (aJ == colsQ - 1'b1);
  assign aLast   = aRowEnd && (aI == rowsQ - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; phase <= '0; done <= 1'b0;
      rowsQ <= '0; colsQ <= '0;
      aValid <= 1'b0; aI <= '0; aJ <= '0;
      bValid <= 1'b0; bI <= '0; bJ <= '0; bLast <= 1'b0;
    end else if (!busy) begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1; phase <= '0;
        rowsQ <= rows; colsQ <= cols;
        aValid <= 1'b1; aI <= '0; aJ <= '0;
        bValid <= 1'b0;
      end
    end else begin
      phase <= phase + 2'd1;
      if (phase == 2'd3) begin
        bValid <= aValid; bI <= aI; bJ <= aJ; bLast <= aValid && aLast;
        if (aValid) begin
          if (aLast) aValid <= 1'b0;
          else if (aRowEnd) begin aJ <= '0; aI <= aI + 1'b1; end
          else aJ <= aJ + 1'b1;
        end
        if (bValid && bLast) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.cfgLoad   = !busy && start;
    strobes.capEn     = busy && aValid && (phase != 2'd0);
    strobes.capIdx    = phase - 2'd1;
    strobes.gradLoad  = busy && bValid && (phase == 2'd0);
    strobes.sqLoad    = busy && bValid && (phase == 2'd1);
    strobes.mulSecond = (phase == 2'd2);
    strobes.outLoad   = busy && bValid && (phase == 2'd2);
  end

  assign rdEn      = busy && aValid && (phase != 2'd3);
  assign rdRowBase = {1'b0, aI};
  assign rdCol     = {1'b0, aJ} + {{(AW-2){1'b0}}, phase};
  assign outRow    = bI;
  assign outCol    = bJ;
endmodule

// File: rtl/sobelDatapath.sv
module sobelDatapath
  import sobelPkg::*;
#(
  parameter int PIX_W = 8,
  parameter int DIM_W = 4,
  localparam int AW     = DIM_W + 1,
  localparam int GRAD_W = PIX_W + 3,
  localparam int ACC_W  = 2 * GRAD_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  sobelStrobes_t         strobes,
  input  logic [ACC_W-1:0]      threshold,
  input  logic [2:0][PIX_W-1:0] rdData,
  input  logic [DIM_W-1:0]      outRow,
  input  logic [DIM_W-1:0]      outCol,
  output logic                  wrEn,
  output logic [2*AW-1:0]       wrAddr,
  output logic                  wrFlag
);
  logic [PIX_W-1:0] win [3][3];
  logic [ACC_W-1:0] thrQ, sqQ, sqNow, magnitude;
  logic signed [GRAD_W-1:0] e1, e2, e1Q, e2Q, mulIn;
  logic signed [ACC_W-1:0]  mulWide, product;

  function automatic logic signed [GRAD_W-1:0] ext(input logic [PIX_W-1:0] p);
    return $signed({3'b000, p});
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.capEn)
      for (int k = 0; k < 3; k++) win[k][strobes.capIdx] <= rdData[k];
  end

  // top row minus bottom row, left column minus right column
  assign e1 = ((ext(win[0][0]) + ext(win[0][1])) + (ext(win[0][1]) + ext(win[0][2])))
            - ((ext(win[2][0]) + ext(win[2][1])) + (ext(win[2][1]) + ext(win[2][2])));
  assign e2 = ((ext(win[0][0]) + ext(win[1][0])) + (ext(win[1][0]) + ext(win[2][0])))
            - ((ext(win[0][2]) + ext(win[1][2])) + (ext(win[1][2]) + ext(win[2][2])));

  // one multiplier, two squarings per interval
  assign mulIn     = strobes.mulSecond ? e2Q : e1Q;
  assign mulWide   = ACC_W'(mulIn);
  assign product   = mulWide * mulWide;
  assign sqNow     = $unsigned(product);
  assign magnitude = sqQ + sqNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrQ <= '0; e1Q <= '0; e2Q <= '0; sqQ <= '0;
      wrEn <= 1'b0; wrAddr <= '0; wrFlag <= 1'b0;
    end else begin
      if (strobes.cfgLoad)  thrQ <= threshold;
      if (strobes.gradLoad) begin e1Q <= e1; e2Q <= e2; end
      if (strobes.sqLoad)   sqQ <= sqNow;
      wrEn <= strobes.outLoad;
      if (strobes.outLoad) begin
        wrAddr <= {1'b0, outRow, 1'b0, outCol};
        wrFlag <= (magnitude > thrQ);
      end
    end
  end
endmodule

// File: rtl/sobelEdgeAccel.sv
module sobelEdgeAccel
  import sobelPkg::*;
#(
  parameter int PIX_W = 8,
  parameter int DIM_W = 4,
  localparam int AW    = DIM_W + 1,
  localparam int THR_W = 2 * (PIX_W + 3)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [DIM_W-1:0]      rows,
  input  logic [DIM_W-1:0]      cols,
  input  logic [THR_W-1:0]      threshold,
  output logic                  rdEn,
  output logic [2:0][2*AW-1:0]  rdAddr,
  input  logic [2:0][PIX_W-1:0] rdData,
  output logic                  wrEn,
  output logic [2*AW-1:0]       wrAddr,
  output logic                  wrFlag,
  output logic                  done
);
  sobelStrobes_t    strobes;
  logic [AW-1:0]    rdRowBase, rdCol;
  logic [DIM_W-1:0] outRow, outCol;

  sobelCtrl #(.DIM_W(DIM_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .rows(rows), .cols(cols),
    .strobes(strobes), .rdEn(rdEn), .rdRowBase(rdRowBase), .rdCol(rdCol),
    .outRow(outRow), .outCol(outCol), .done(done)
  );

  for (genvar k = 0; k < 3; k++) begin : gPort
    assign rdAddr[k] = {rdRowBase + AW'(k), rdCol};
  end

  sobelDatapath #(.PIX_W(PIX_W), .DIM_W(DIM_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .threshold(threshold),
    .rdData(rdData), .outRow(outRow), .outCol(outCol),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrFlag(wrFlag)
  );
endmodule

// File: rtl/sobelEdgeAccelChk.sv
module sobelEdgeAccelChk #(
  parameter int DIM_W = 4,
  localparam int AW = DIM_W + 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdEn,
  input logic [2:0][2*AW-1:0] rdAddr,
  input logic                 wrEn,
  input logic                 done
);
  logic [2:0] gapCnt;
  logic       seenWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0; seenWr <= 1'b0;
    end else begin
      if (wrEn) gapCnt <= 3'd1;
      else if (gapCnt != 3'd7) gapCnt <= gapCnt + 3'd1;
      if (done) seenWr <= 1'b0;
      else if (wrEn) seenWr <= 1'b1;
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rstN |=> (!rdEn && !wrEn && !done));

  a_r2_column_step: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn)) |-> (rdAddr[0][AW-1:0] == $past(rdAddr[0][AW-1:0]) + 1'b1));

  a_r2_row_offsets: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> ((rdAddr[1][2*AW-1:AW] == rdAddr[0][2*AW-1:AW] + 1'b1) &&
              (rdAddr[2][2*AW-1:AW] == rdAddr[0][2*AW-1:AW] + 2'd2)));

  a_r2_burst_of_three: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(rdEn) && $past(rdEn, 2)) |=> !rdEn);

  a_r5_single_write: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  a_r5_write_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && seenWr) |-> (gapCnt == 3'd4));

  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(wrEn));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind sobelEdgeAccel sobelEdgeAccelChk #(.DIM_W(DIM_W)) uChk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn), .done(done)
);

// File: tb/sim_sobelEdgeAccel.sv
`timescale 1ns/1ps
module sim_sobelEdgeAccel;
  localparam int PIX_W = 8;
  localparam int DIM_W = 4;
  localparam int AW    = DIM_W + 1;
  localparam int THR_W = 2 * (PIX_W + 3);
  localparam int RSTR  = 1 << AW;   // row stride in the address layout

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  start = 1'b0;
  logic [DIM_W-1:0]      rows = '0, cols = '0;
  logic [THR_W-1:0]      threshold = '0;
  logic                  rdEn, wrEn, wrFlag, done;
  logic [2:0][2*AW-1:0]  rdAddr;
  logic [2:0][PIX_W-1:0] rdData;
  logic [2*AW-1:0]       wrAddr;

  logic [PIX_W-1:0] img [0:RSTR*RSTR-1];
  int expFlag [0:15][0:15];
  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  sobelEdgeAccel #(.PIX_W(PIX_W), .DIM_W(DIM_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .rows(rows), .cols(cols),
    .threshold(threshold), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrFlag(wrFlag), .done(done)
  );

  // three read ports onto one image, one-cycle latency
  always_ff @(posedge clk) begin
    for (int k = 0; k < 3; k++)
      if (rdEn) rdData[k] <= img[rdAddr[k]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int px(input int r, input int c);
    return int'(img[r*RSTR + c]);
  endfunction

  task automatic runCase(input int nr, input int nc, input longint thr,
                         input int mode, input bit midStart, input string flagTag);
    int n = nr * nc;
    string wTag = midStart ? "R8" : "R4";
    for (int r = 0; r < nr + 2; r++)
      for (int c = 0; c < nc + 2; c++)
        case (mode)
          0: img[r*RSTR + c] = PIX_W'($urandom_range(0, 255));
          1: img[r*RSTR + c] = 8'd77;
          2: img[r*RSTR + c] = PIX_W'(r*17 + c*5);
          default: img[r*RSTR + c] = ($urandom_range(0, 1) != 0) ? 8'd255 : 8'd0;
        endcase
    for (int i = 0; i < nr; i++)
      for (int j = 0; j < nc; j++) begin
        int e1 = (px(i,j) + 2*px(i,j+1) + px(i,j+2)) - (px(i+2,j) + 2*px(i+2,j+1) + px(i+2,j+2));
        int e2 = (px(i,j) + 2*px(i+1,j) + px(i+2,j)) - (px(i,j+2) + 2*px(i+1,j+2) + px(i+2,j+2));
        longint e = longint'(e1*e1) + longint'(e2*e2);
        expFlag[i][j] = (e > thr) ? 1 : 0;
      end
    @(negedge clk);
    rows = DIM_W'(nr); cols = DIM_W'(nc); threshold = THR_W'(thr); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 4*n + 8; cyc++) begin
      int p = cyc / 4, ph = cyc % 4;
      bit expRd = (p < n) && (ph < 3);
      int wp = (cyc - 7) / 4;
      bit expWr = (cyc >= 7) && ((cyc - 7) % 4 == 0) && (wp < n);
      chk(rdEn == expRd, "R2", "rdEn", rdEn, expRd);
      if (cyc == 0) chk(rdEn == 1'b1, "R6", "first read", rdEn, 1);
      if (expRd)
        for (int k = 0; k < 3; k++) begin
          int ea = ((p / nc) + k) * RSTR + (p % nc) + ph;
          chk(int'(rdAddr[k]) == ea, "R2", "rdAddr", rdAddr[k], ea);
        end
      chk(wrEn == expWr, "R5", "wrEn", wrEn, expWr);
      if (cyc == 7) chk(wrEn == 1'b1, "R6", "first write", wrEn, 1);
      if (expWr) begin
        int ea = (wp / nc) * RSTR + (wp % nc);
        chk(int'(wrAddr) == ea, wTag, "wrAddr", wrAddr, ea);
        chk(int'(wrFlag) == expFlag[wp/nc][wp%nc], flagTag, "wrFlag",
            wrFlag, expFlag[wp/nc][wp%nc]);
      end
      chk(done == (cyc == 4*n + 4), "R7", "done", done, (cyc == 4*n + 4));
      if (midStart && cyc == 5) begin
        start = 1'b1; rows = 1; cols = 1; threshold = '0;
      end else start = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rdEn && !wrEn && !done, "R1", "outputs in reset", {rdEn, wrEn, done}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rdEn && !wrEn && !done, "R1", "outputs after reset", {rdEn, wrEn, done}, 0);

    runCase(4, 5, $urandom_range(0, 300000), 0, 1'b0, "R3");
    runCase(3, 3, 0, 0, 1'b0, "R9");            // zero threshold
    runCase(3, 4, (1 << THR_W) - 1, 0, 1'b0, "R9"); // maximal threshold
    runCase(3, 3, 0, 1, 1'b0, "R9");            // flat image, sum equals 0
    runCase(4, 4, 20096, 2, 1'b0, "R9");        // ramp: sum equals threshold
    runCase(4, 4, 20095, 2, 1'b0, "R9");        // ramp: one below
    runCase(3, 5, 60000, 3, 1'b0, "R3");
    for (int a = 1; a <= 4; a++)
      for (int b = 1; b <= 4; b++)
        runCase(a, b, $urandom_range(0, 400000), 0, 1'b0, "R3");
    runCase(5, 6, 100000, 0, 1'b1, "R8");       // start mid-run ignored
    runCase(13, 13, $urandom_range(0, 500000), 0, 1'b0, "R3");
    repeat (4) @(negedge clk);
    chk(!rdEn && !wrEn && !done, "R7", "idle after runs", {rdEn, wrEn, done}, 0);
    finishRun();
  end
endmodule